// File: doc/BRIEF.md
# Reset Cause and Status Flag Controller

This block owns the two read-only status flags that tell software how the processor core last left reset or sleep. The time-out flag (`to_n_o`) and the power-down flag (`pd_n_o`) are both active low. The block also decides where execution resumes. A reset restarts at the reset vector and clears the bank-select bits. A wake from sleep, caused by a watchdog expiry or an interrupt, continues at the instruction after the sleep instruction.

The block takes one-cycle event strobes:
- a power-on event,
- an external clear,
- a watchdog expiry,
- an interrupt wake,
- execution of a sleep instruction,
- execution of a clear-watchdog instruction.

It also takes the current program counter. It tracks the sleeping state internally and reports it on `asleep_o`. When several strobes arrive in one cycle, a fixed priority picks one winner. That winner's effect is registered, so the flags, the program-counter load strobe and the bank clear all appear in the cycle after the event.

Top module: `rstcause_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `to_n_o`=1, `pd_n_o`=1 and `asleep_o`=0, with `pc_load_o`=0 and `bank_clr_o`=0.
- R2: A power-on strobe sets `to_n_o`=1 and `pd_n_o`=1 and clears the sleeping state. In the next cycle it raises `pc_load_o` with `pc_next_o`=RESET_VEC (default 0) and raises all `bank_clr_o` bits.
- R3: An external clear while awake leaves `to_n_o` and `pd_n_o` unchanged. It loads RESET_VEC and clears the bank bits.
- R4: An external clear while asleep sets `to_n_o`=1 and `pd_n_o`=0 and leaves sleep. It loads RESET_VEC and clears the bank bits.
- R5: A watchdog expiry while awake sets `to_n_o`=0 and `pd_n_o`=1. It loads RESET_VEC and clears the bank bits.
- R6: A watchdog expiry while asleep sets `to_n_o`=0 and `pd_n_o`=0 and leaves sleep. It loads `pc_i`+1, wrapping modulo 2^PC_W, and leaves `bank_clr_o`=0.
- R7: An interrupt wake while asleep sets `to_n_o`=1 and `pd_n_o`=0, leaves sleep and loads `pc_i`+1 without a bank clear. An interrupt wake while awake has no effect.
- R8: A sleep instruction while awake sets `to_n_o`=1 and `pd_n_o`=0 and enters the sleeping state, with no program-counter load.
- R9: A clear-watchdog instruction while awake sets `to_n_o`=1 and `pd_n_o`=1, with no program-counter load. If it coincides with a sleep instruction, the sleep instruction wins.
- R10: Instruction strobes received while asleep are ignored: the flags and the sleeping state hold.
- R11: Coincident strobes resolve in this order: power-on, external clear, watchdog expiry, interrupt wake, sleep instruction, clear-watchdog instruction.
- R12: `pc_load_o` and `bank_clr_o` are single-cycle pulses one cycle after the qualifying event. Without a qualifying strobe, the flags hold and `pc_load_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_evt_i | input | 1 | Power-on event strobe |
| xclr_evt_i | input | 1 | External clear strobe |
| wdt_evt_i | input | 1 | Watchdog expiry strobe |
| irq_wake_i | input | 1 | Interrupt wake strobe |
| sleep_op_i | input | 1 | Sleep instruction executed |
| clrwdt_op_i | input | 1 | Clear-watchdog instruction executed |
| pc_i | input | PC_W | Current program counter |
| to_n_o | output | 1 | Time-out flag, active low |
| pd_n_o | output | 1 | Power-down flag, active low |
| asleep_o | output | 1 | Core is in the sleeping state |
| pc_load_o | output | 1 | Program-counter load strobe |
| pc_next_o | output | PC_W | Address to load |
| bank_clr_o | output | BANK_W | Clear for the bank-select bits |

## Verification
Directed sequences put each event through both the awake and the asleep state, because the same strobe must give different flags and resume addresses in the two states. A watchdog wake at the top address checks that the program-counter increment wraps. Multi-strobe cycles in each state separate a correct priority from one that merges effects. Random strobe mixes, biased toward collisions and toward ignored instructions during sleep, are compared every cycle against a bench model.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

  // Winning event after priority resolution
  typedef enum logic [3:0] {
    EV_NONE,
    EV_POR,
    EV_XCLR_AWAKE,
    EV_XCLR_SLEEP,
    EV_WDT_AWAKE,
    EV_WDT_SLEEP,
    EV_IRQ_WAKE,
    EV_SLEEP_OP,
    EV_CLRWDT_OP
  } rc_event_e;

  // Source indices, lowest index wins
  localparam int SRC_POR    = 0;
  localparam int SRC_XCLR   = 1;
  localparam int SRC_WDT    = 2;
  localparam int SRC_IRQ    = 3;
  localparam int SRC_SLEEP  = 4;
  localparam int SRC_CLRWDT = 5;
  localparam int N_SRC      = 6;

  typedef struct packed {
    logic wr_to;      // update time-out flag
    logic to_val;
    logic wr_pd;      // update power-down flag
    logic pd_val;
    logic sleep_set;
    logic sleep_clr;
    logic pc_ld;      // issue a program-counter load
    logic to_vector;  // load the vector (else PC+1) and clear banks
  } rc_action_t;

  function automatic rc_action_t rc_decode(rc_event_e ev);
    rc_action_t a;
    a = '0;
    unique case (ev)
      EV_POR: begin
        a.wr_to = 1'b1; a.to_val = 1'b1;
        a.wr_pd = 1'b1; a.pd_val = 1'b1;
        a.sleep_clr = 1'b1; a.pc_ld = 1'b1; a.to_vector = 1'b1;
      end
      EV_XCLR_AWAKE: begin
        a.pc_ld = 1'b1; a.to_vector = 1'b1;
      end
      EV_XCLR_SLEEP: begin
        a.wr_to = 1'b1; a.to_val = 1'b1;
        a.wr_pd = 1'b1; a.pd_val = 1'b0;
        a.sleep_clr = 1'b1; a.pc_ld = 1'b1; a.to_vector = 1'b1;
      end
      EV_WDT_AWAKE: begin
        a.wr_to = 1'b1; a.to_val = 1'b0;
        a.wr_pd = 1'b1; a.pd_val = 1'b1;
        a.pc_ld = 1'b1; a.to_vector = 1'b1;
      end
      EV_WDT_SLEEP: begin
        a.wr_to = 1'b1; a.to_val = 1'b0;
        a.wr_pd = 1'b1; a.pd_val = 1'b0;
        a.sleep_clr = 1'b1; a.pc_ld = 1'b1;
      end
      EV_IRQ_WAKE: begin
        a.wr_to = 1'b1; a.to_val = 1'b1;
        a.wr_pd = 1'b1; a.pd_val = 1'b0;
        a.sleep_clr = 1'b1; a.pc_ld = 1'b1;
      end
      EV_SLEEP_OP: begin
        a.wr_to = 1'b1; a.to_val = 1'b1;
        a.wr_pd = 1'b1; a.pd_val = 1'b0;
        a.sleep_set = 1'b1;
      end
      EV_CLRWDT_OP: begin
        a.wr_to = 1'b1; a.to_val = 1'b1;
        a.wr_pd = 1'b1; a.pd_val = 1'b1;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/rc_event_arb.sv
module rc_event_arb
  import rstcause_pkg::*;
(
  input  logic      por_i,
  input  logic      xclr_i,
  input  logic      wdt_i,
  input  logic      irq_i,
  input  logic      sleep_i,
  input  logic      clrwdt_i,
  input  logic      asleep_i,
  output rc_event_e ev_o
);

  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] win;

  // Gate sources that only qualify in one state
  always_comb begin
    req             = '0;
    req[SRC_POR]    = por_i;
    req[SRC_XCLR]   = xclr_i;
    req[SRC_WDT]    = wdt_i;
    req[SRC_IRQ]    = irq_i    &  asleep_i;
    req[SRC_SLEEP]  = sleep_i  & ~asleep_i;
    req[SRC_CLRWDT] = clrwdt_i & ~asleep_i;
  end

  // Fixed-priority one-hot pick, lowest index first
  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_pick
      if (g == 0) begin : g_first
        assign win[g] = req[g];
      end else begin : g_rest
        assign win[g] = req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    ev_o = EV_NONE;
    if (win[SRC_POR])         ev_o = EV_POR;
    else if (win[SRC_XCLR])   ev_o = asleep_i ? EV_XCLR_SLEEP : EV_XCLR_AWAKE;
    else if (win[SRC_WDT])    ev_o = asleep_i ? EV_WDT_SLEEP  : EV_WDT_AWAKE;
    else if (win[SRC_IRQ])    ev_o = EV_IRQ_WAKE;
    else if (win[SRC_SLEEP])  ev_o = EV_SLEEP_OP;
    else if (win[SRC_CLRWDT]) ev_o = EV_CLRWDT_OP;
  end

endmodule

// File: rtl/rc_flag_reg.sv
module rc_flag_reg
  import rstcause_pkg::*;
#(
  parameter logic TO_RST = 1'b1,
  parameter logic PD_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  rc_action_t act_i,
  output logic       to_n_o,
  output logic       pd_n_o,
  output logic       asleep_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      to_n_o   <= TO_RST;
      pd_n_o   <= PD_RST;
      asleep_o <= 1'b0;
    end else begin
      if (act_i.wr_to) to_n_o <= act_i.to_val;
      if (act_i.wr_pd) pd_n_o <= act_i.pd_val;
      if (act_i.sleep_clr)      asleep_o <= 1'b0;
      else if (act_i.sleep_set) asleep_o <= 1'b1;
    end
  end

endmodule

// File: rtl/rc_resume.sv
module rc_resume
  import rstcause_pkg::*;
#(
  parameter int          PC_W      = 13,
  parameter int          BANK_W    = 3,
  parameter int unsigned RESET_VEC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  rc_action_t        act_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   pc_next_o,
  output logic [BANK_W-1:0] bank_clr_o
);

  localparam logic [PC_W-1:0] VEC = PC_W'(RESET_VEC);

  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc_i + {{(PC_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load_o  <= 1'b0;
      pc_next_o  <= VEC;
      bank_clr_o <= '0;
    end else begin
      pc_load_o  <= act_i.pc_ld;
      bank_clr_o <= {BANK_W{act_i.pc_ld & act_i.to_vector}};
      if (act_i.pc_ld) pc_next_o <= act_i.to_vector ? VEC : pc_inc;
    end
  end

endmodule

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rstcause_pkg::*;
#(
  parameter int          PC_W      = 13,
  parameter int          BANK_W    = 3,
  parameter int unsigned RESET_VEC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por_evt_i,
  input  logic              xclr_evt_i,
  input  logic              wdt_evt_i,
  input  logic              irq_wake_i,
  input  logic              sleep_op_i,
  input  logic              clrwdt_op_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              to_n_o,
  output logic              pd_n_o,
  output logic              asleep_o,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   pc_next_o,
  output logic [BANK_W-1:0] bank_clr_o
);

  rc_event_e  ev;
  rc_action_t act;

  rc_event_arb u_arb (
    .por_i    (por_evt_i),
    .xclr_i   (xclr_evt_i),
    .wdt_i    (wdt_evt_i),
    .irq_i    (irq_wake_i),
    .sleep_i  (sleep_op_i),
    .clrwdt_i (clrwdt_op_i),
    .asleep_i (asleep_o),
    .ev_o     (ev)
  );

  assign act = rc_decode(ev);

  rc_flag_reg u_flags (
    .clk      (clk),
    .rst      (rst),
    .act_i    (act),
    .to_n_o   (to_n_o),
    .pd_n_o   (pd_n_o),
    .asleep_o (asleep_o)
  );

  rc_resume #(
    .PC_W      (PC_W),
    .BANK_W    (BANK_W),
    .RESET_VEC (RESET_VEC)
  ) u_resume (
    .clk        (clk),
    .rst        (rst),
    .act_i      (act),
    .pc_i       (pc_i),
    .pc_load_o  (pc_load_o),
    .pc_next_o  (pc_next_o),
    .bank_clr_o (bank_clr_o)
  );

endmodule

// File: rtl/rstcause_ctrl_chk.sv
module rstcause_ctrl_chk #(
  parameter int          PC_W      = 13,
  parameter int          BANK_W    = 3,
  parameter int unsigned RESET_VEC = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              por_evt_i,
  input logic              xclr_evt_i,
  input logic              wdt_evt_i,
  input logic              irq_wake_i,
  input logic              sleep_op_i,
  input logic              clrwdt_op_i,
  input logic [PC_W-1:0]   pc_i,
  input logic              to_n_o,
  input logic              pd_n_o,
  input logic              asleep_o,
  input logic              pc_load_o,
  input logic [PC_W-1:0]   pc_next_o,
  input logic [BANK_W-1:0] bank_clr_o
);

  logic [PC_W-1:0] pc_plus1;
  logic            hi_free;
  logic            any_evt;
  assign pc_plus1 = pc_i + 1'b1;
  assign hi_free  = !por_evt_i && !xclr_evt_i;
  assign any_evt  = por_evt_i || xclr_evt_i || wdt_evt_i || irq_wake_i ||
                    sleep_op_i || clrwdt_op_i;

  // R2
  por_restart_chk: assert property (@(posedge clk) disable iff (rst)
    por_evt_i |=> to_n_o && pd_n_o && !asleep_o && pc_load_o &&
                  pc_next_o == PC_W'(RESET_VEC) && (&bank_clr_o));

  // R3
  xclr_awake_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !por_evt_i && xclr_evt_i && !asleep_o |=>
      $stable(to_n_o) && $stable(pd_n_o) && pc_load_o && (&bank_clr_o));

  // R5
  wdt_awake_chk: assert property (@(posedge clk) disable iff (rst)
    hi_free && wdt_evt_i && !asleep_o |=>
      !to_n_o && pd_n_o && pc_load_o && pc_next_o == PC_W'(RESET_VEC));

  // R6
  wdt_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    hi_free && wdt_evt_i && asleep_o |=>
      !to_n_o && !pd_n_o && !asleep_o && pc_load_o &&
      pc_next_o == $past(pc_plus1) && bank_clr_o == '0);

  // R10
  asleep_ignore_op_chk: assert property (@(posedge clk) disable iff (rst)
    asleep_o && !any_evt |=> asleep_o && $stable(to_n_o) && $stable(pd_n_o));

  // R10
  asleep_ignore_op2_chk: assert property (@(posedge clk) disable iff (rst)
    asleep_o && hi_free && !wdt_evt_i && !irq_wake_i |=>
      asleep_o && $stable(to_n_o) && $stable(pd_n_o) && !pc_load_o);

  // R12
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_evt |=> $stable(to_n_o) && $stable(pd_n_o) && !pc_load_o &&
                 bank_clr_o == '0);

  // R12
  bank_with_load_chk: assert property (@(posedge clk) disable iff (rst)
    (|bank_clr_o) |-> pc_load_o && (&bank_clr_o));

endmodule

bind rstcause_ctrl rstcause_ctrl_chk #(
  .PC_W      (PC_W),
  .BANK_W    (BANK_W),
  .RESET_VEC (RESET_VEC)
) u_chk (.*);

// File: tb/rstcause_ctrl_bench.sv
module rstcause_ctrl_bench;

  localparam int PC_W   = 13;
  localparam int BANK_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              por = 0, xclr = 0, wdt = 0, irq = 0, slp = 0, cwd = 0;
  logic [PC_W-1:0]   pc = '0;
  logic              to_n, pd_n, asleep, pc_load;
  logic [PC_W-1:0]   pc_next;
  logic [BANK_W-1:0] bank_clr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic m_to = 1, m_pd = 1, m_sl = 0;

  always #2 clk = ~clk;   // 250 MHz

  rstcause_ctrl #(.PC_W(PC_W), .BANK_W(BANK_W), .RESET_VEC(0)) u_rstcause_ctrl (
    .clk(clk), .rst(rst),
    .por_evt_i(por), .xclr_evt_i(xclr), .wdt_evt_i(wdt), .irq_wake_i(irq),
    .sleep_op_i(slp), .clrwdt_op_i(cwd), .pc_i(pc),
    .to_n_o(to_n), .pd_n_o(pd_n), .asleep_o(asleep),
    .pc_load_o(pc_load), .pc_next_o(pc_next), .bank_clr_o(bank_clr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Expected next state from the requirements (R2..R11 priority order)
  task automatic model(input logic p, x, w, i, s, c, input logic [PC_W-1:0] cur_pc,
                       output logic ld, output logic bk, output logic [PC_W-1:0] nx);
    ld = 0; bk = 0; nx = '0;
    if (p) begin
      m_to = 1; m_pd = 1; m_sl = 0; ld = 1; bk = 1;
    end else if (x) begin
      if (m_sl) begin m_to = 1; m_pd = 0; end
      m_sl = 0; ld = 1; bk = 1;
    end else if (w) begin
      m_to = 0; ld = 1;
      if (m_sl) begin m_pd = 0; nx = cur_pc + 1'b1; end
      else      begin m_pd = 1; bk = 1; end
      m_sl = 0;
    end else if (i && m_sl) begin
      m_to = 1; m_pd = 0; m_sl = 0; ld = 1; nx = cur_pc + 1'b1;
    end else if (s && !m_sl) begin
      m_to = 1; m_pd = 0; m_sl = 1;
    end else if (c && !m_sl) begin
      m_to = 1; m_pd = 1;
    end
  endtask

  // Called at a negedge; drives one cycle of strobes and checks the result
  task automatic step(input logic p, x, w, i, s, c, input logic [PC_W-1:0] cur_pc,
                      input string tag);
    logic ld, bk;
    logic [PC_W-1:0] nx;
    model(p, x, w, i, s, c, cur_pc, ld, bk, nx);
    por = p; xclr = x; wdt = w; irq = i; slp = s; cwd = c; pc = cur_pc;
    @(negedge clk);
    por = 0; xclr = 0; wdt = 0; irq = 0; slp = 0; cwd = 0;
    chk(to_n == m_to,       tag, "to_n",     to_n,     m_to);
    chk(pd_n == m_pd,       tag, "pd_n",     pd_n,     m_pd);
    chk(asleep == m_sl,     tag, "asleep",   asleep,   m_sl);
    chk(pc_load == ld,      tag, "pc_load",  pc_load,  ld);
    chk(bank_clr == {BANK_W{bk}}, tag, "bank_clr", bank_clr, {BANK_W{bk}});
    if (ld) chk(pc_next == nx, tag, "pc_next", pc_next, nx);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(to_n == 1 && pd_n == 1, "R1", "flags", {to_n, pd_n}, 2'b11);
    chk(!asleep && !pc_load && bank_clr == '0, "R1", "asleep/load/bank",
        {asleep, pc_load, bank_clr}, 0);

    step(0,0,0,0,1,0, 13'h010, "R8 sleep op");
    step(0,0,0,0,0,1, 13'h011, "R10 clrwdt while asleep");
    step(0,0,0,0,1,0, 13'h011, "R10 sleep while asleep");
    step(0,0,0,1,0,0, 13'h055, "R7 irq wake");
    step(0,0,0,1,0,0, 13'h060, "R7 irq while awake ignored");
    step(0,0,0,0,0,1, 13'h061, "R9 clrwdt");
    step(0,0,1,0,0,0, 13'h070, "R5 wdt awake");
    step(0,1,0,0,0,0, 13'h071, "R3 xclr awake");
    step(0,0,0,0,1,0, 13'h072, "R8 sleep op");
    step(0,0,1,0,0,0, 13'h1FFF, "R6 wdt asleep wrap");
    step(0,0,0,0,1,0, 13'h0A0, "R8 sleep op");
    step(0,1,0,0,0,0, 13'h0A1, "R4 xclr asleep");
    step(0,0,1,0,0,0, 13'h0B0, "R5 wdt awake");
    step(1,0,0,0,0,0, 13'h0B1, "R2 power-on");
    step(0,0,0,0,1,1, 13'h0C0, "R9 sleep beats clrwdt");
    step(1,1,1,1,1,1, 13'h0C1, "R11 all strobes");
    step(0,0,0,0,1,0, 13'h0D0, "R8 sleep op");
    step(0,1,1,1,0,0, 13'h0D1, "R11 xclr over wdt asleep");
    step(0,0,0,0,1,0, 13'h0E0, "R8 sleep op");
    step(0,0,1,1,1,1, 13'h0E1, "R11 wdt over irq asleep");
    step(0,0,0,0,1,0, 13'h0F0, "R8 sleep op");
    step(0,0,0,1,1,1, 13'h0F1, "R11 irq over ops asleep");
    step(0,0,0,0,0,0, 13'h0F2, "R12 idle");
    step(0,0,1,0,0,1, 13'h100, "R11 wdt over clrwdt awake");
    step(0,0,0,0,0,0, 13'h101, "R12 idle after load");

    void'($urandom(32'd24681));
    for (int n = 0; n < 3000; n++) begin
      logic p, x, w, i, s, c;
      p = ($urandom % 40) == 0;
      x = ($urandom % 20) == 0;
      w = ($urandom % 10) == 0;
      i = ($urandom % 6)  == 0;
      s = ($urandom % 5)  == 0;
      c = ($urandom % 5)  == 0;
      step(p, x, w, i, s, c, PC_W'($urandom), "R11 random mix");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule